// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block keeps a table of sixteen programmable address windows and resolves every incoming transaction address against all of them at once. Each window spans a range with 1 MB granularity and names a 4-bit target. A lookup supplies a 48-bit address, a direction flag and a secure flag. One cycle later the block returns whether a window claimed the address, which window it was, the target it routes to, and whether the access broke that window's secure-only rules.

Windows are programmed through a 32-bit register port. Each window has a block of five registers: control, security, start bound, end bound and a plain route-flag register. Window 0 is the configuration window. It cannot be switched off, it always spans 16 MB from its programmed start, and its end register has no effect on decoding. When several windows overlap, the lowest-numbered one wins.

Top module: `awdDecoderTop`

## Requirements
- R1: After reset, window 0 control reads 0x00000001 (enabled, target 0, start 0). Every other register of every window reads 0.
- R2: Register byte address = window × 0x20 + offset. The offsets are control 0x0, security 0x4, start 0x8, end 0xC and route flags 0x10. Read data appears on regRdata in the cycle after regRdEn. Offsets 0x14 to 0x1C read 0, and writes to them are dropped. Route flags are plain storage.
- R3: Start and end registers always read bits [3:0] as 0. Their bits [31:4] hold address bits [47:20].
- R4: Bit 0 (enable) of window 0 control always reads 1, whatever was written. Its other bits read back as written.
- R5: A window n ≥ 1 matches when control bit 0 is 1 and start[31:4] ≤ addr[47:20] ≤ end[31:4]. Both bounds are inclusive.
- R6: Window 0 matches when start[31:4] ≤ addr[47:20] < start[31:4] + 16. Its end register is ignored.
- R7: On a hit, resTarget is control bits [11:8] of the selected window and resWin is that window's number.
- R8: When several windows match, the lowest-numbered one is selected.
- R9: On a miss, resHit = 0, resTarget = 0, resWin = 0 and resViolation = 0.
- R10: Security bits: bit 0 makes writes secure-only and bit 1 makes reads secure-only for window 0; bits 2 (write) and 3 (read) do the same for windows 1–15. A non-secure access to a selected window whose bit is set gives resViolation = 1, resHit = 0, resTarget = 0 and resWin = that window. A secure access is never a violation.
- R11: resValid is 1 exactly in the cycle after lkValid was 1. The result fields update only on a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 9 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, one cycle after regRdEn |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 48 | Lookup address |
| lkWrite | input | 1 | 1 = write access, 0 = read access |
| lkSecure | input | 1 | 1 = secure access |
| resValid | output | 1 | Result valid |
| resHit | output | 1 | Address claimed without violation |
| resTarget | output | 4 | Target of the selected window |
| resWin | output | 4 | Selected window number |
| resViolation | output | 1 | Secure-only rule broken |

## Verification
A corrupted bound or enable bit shows up on the very next lookup that lands near the affected range. It appears as a wrong resHit or resWin one cycle after lkValid, and the same fault also appears on a register read one cycle after regRdEn. Lookups are aimed at both sides of every programmed bound, with overlapping windows. That way an off-by-one compare, a wrong priority order or a wrong choice of security bit changes at least one result field at once. A wrong write path stays invisible until the affected register is read, so random reads are mixed in alongside the lookups.

// File: rtl/awd_pkg.sv
package awd_pkg;

  typedef enum logic [2:0] {
    FLD_CTRL  = 3'd0,
    FLD_SEC   = 3'd1,
    FLD_LOW   = 3'd2,
    FLD_HIGH  = 3'd3,
    FLD_ROUTE = 3'd4
  } fieldSel_e;

  // Strobes passed from register control to the datapath
  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        mapped;
    fieldSel_e   field;
    logic [31:0] data;
  } regStrobe_t;

endpackage

// File: rtl/awdRegCtrl.sv
module awdRegCtrl
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 16,
  localparam int WIN_IW = $clog2(NUM_WIN),
  localparam int REG_AW = WIN_IW + 5
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output regStrobe_t        stb,
  output logic [WIN_IW-1:0] winSel
);

  logic [2:0] fieldRaw;
  logic       winOk;
  logic       unusedByteLane;

  assign unusedByteLane = ^regAddr[1:0];
  assign fieldRaw       = regAddr[4:2];
  assign winSel         = regAddr[REG_AW-1:5];
  assign winOk          = ({1'b0, winSel} < (WIN_IW+1)'(NUM_WIN));

  always_comb begin
    stb        = '0;
    stb.wr     = regWrEn;
    stb.rd     = regRdEn;
    stb.field  = fieldSel_e'(fieldRaw);
    stb.mapped = winOk && (fieldRaw <= 3'd4);
    stb.data   = regWdata;
  end

endmodule

// File: rtl/awdDatapath.sv
module awdDatapath
  import awd_pkg::*;
#(
  parameter int NUM_WIN     = 16,
  parameter int ADDR_W      = 48,
  parameter int TID_W       = 4,
  parameter int CFG_SPAN_MB = 16,
  localparam int WIN_IW = $clog2(NUM_WIN),
  localparam int GRAN_SH = 20,
  localparam int GW = ADDR_W - GRAN_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [WIN_IW-1:0] winSel,
  output logic [31:0]       regRdata,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  input  logic              lkSecure,
  output logic              resValid,
  output logic              resHit,
  output logic [TID_W-1:0]  resTarget,
  output logic [WIN_IW-1:0] resWin,
  output logic              resViolation
);

  logic [31:0] ctrlQ  [NUM_WIN];
  logic [31:0] secQ   [NUM_WIN];
  logic [31:0] lowQ   [NUM_WIN];
  logic [31:0] highQ  [NUM_WIN];
  logic [31:0] routeQ [NUM_WIN];

  // register storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        ctrlQ[w]  <= (w == 0) ? 32'h1 : 32'h0;
        secQ[w]   <= '0;
        lowQ[w]   <= '0;
        highQ[w]  <= '0;
        routeQ[w] <= '0;
      end
    end else if (stb.wr && stb.mapped) begin
      case (stb.field)
        FLD_CTRL:  ctrlQ[winSel]  <= (winSel == '0) ? (stb.data | 32'h1) : stb.data;
        FLD_SEC:   secQ[winSel]   <= stb.data;
        FLD_LOW:   lowQ[winSel]   <= {stb.data[31:4], 4'h0};
        FLD_HIGH:  highQ[winSel]  <= {stb.data[31:4], 4'h0};
        FLD_ROUTE: routeQ[winSel] <= stb.data;
        default: ;
      endcase
    end
  end

  // readback
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (stb.mapped) begin
      case (stb.field)
        FLD_CTRL:  rdMux = ctrlQ[winSel];
        FLD_SEC:   rdMux = secQ[winSel];
        FLD_LOW:   rdMux = lowQ[winSel];
        FLD_HIGH:  rdMux = highQ[winSel];
        FLD_ROUTE: rdMux = routeQ[winSel];
        default:   rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       regRdata <= '0;
    else if (stb.rd) regRdata <= rdMux;
  end

  // per-window range compare
  logic [GW-1:0]      lkGran;
  logic               unusedLowAddr;
  logic [NUM_WIN-1:0] winMatch;

  assign lkGran        = lkAddr[ADDR_W-1 -: GW];
  assign unusedLowAddr = ^lkAddr[GRAN_SH-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [GW-1:0] loG;
    assign loG = lowQ[w][4 +: GW];
    if (w == 0) begin : g_cfg
      logic [GW:0] endG;
      assign endG        = {1'b0, loG} + (GW+1)'(CFG_SPAN_MB);
      assign winMatch[w] = ctrlQ[w][0] && (lkGran >= loG) && ({1'b0, lkGran} < endG);
    end else begin : g_std
      assign winMatch[w] = ctrlQ[w][0] && (lkGran >= loG) && (lkGran <= highQ[w][4 +: GW]);
    end
  end

  // lowest index wins
  logic              selFound;
  logic [WIN_IW-1:0] selIdx;
  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (winMatch[w] && !selFound) begin
        selFound = 1'b1;
        selIdx   = WIN_IW'(w);
      end
    end
  end

  // bit index: {data window, read}
  logic secBit, violN;
  assign secBit = secQ[selIdx][{selIdx != '0, !lkWrite}];
  assign violN  = selFound && !lkSecure && secBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid     <= 1'b0;
      resHit       <= 1'b0;
      resTarget    <= '0;
      resWin       <= '0;
      resViolation <= 1'b0;
    end else begin
      resValid <= lkValid;
      if (lkValid) begin
        resHit       <= selFound && !violN;
        resTarget    <= (selFound && !violN) ? ctrlQ[selIdx][8 +: TID_W] : '0;
        resWin       <= selFound ? selIdx : '0;
        resViolation <= violN;
      end
    end
  end

  // R11
  res_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> resValid);
  // R11
  res_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !resValid);
  // R10
  secure_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkSecure) |=> !resViolation);
  // R9
  miss_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resTarget == '0));
  // R4
  cfg_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.mapped && winSel == '0 && stb.field == FLD_CTRL) |=> regRdata[0]);
  // R3
  bound_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.mapped && (stb.field == FLD_LOW || stb.field == FLD_HIGH))
      |=> (regRdata[3:0] == 4'h0));

endmodule

// File: rtl/awdDecoderTop.sv
module awdDecoderTop
  import awd_pkg::*;
#(
  parameter int NUM_WIN     = 16,
  parameter int ADDR_W      = 48,
  parameter int TID_W       = 4,
  parameter int CFG_SPAN_MB = 16,
  localparam int WIN_IW = $clog2(NUM_WIN),
  localparam int REG_AW = WIN_IW + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  input  logic              lkSecure,
  output logic              resValid,
  output logic              resHit,
  output logic [TID_W-1:0]  resTarget,
  output logic [WIN_IW-1:0] resWin,
  output logic              resViolation
);

  regStrobe_t        stb;
  logic [WIN_IW-1:0] winSel;

  awdRegCtrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .stb     (stb),
    .winSel  (winSel)
  );

  awdDatapath #(
    .NUM_WIN    (NUM_WIN),
    .ADDR_W     (ADDR_W),
    .TID_W      (TID_W),
    .CFG_SPAN_MB(CFG_SPAN_MB)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .winSel      (winSel),
    .regRdata    (regRdata),
    .lkValid     (lkValid),
    .lkAddr      (lkAddr),
    .lkWrite     (lkWrite),
    .lkSecure    (lkSecure),
    .resValid    (resValid),
    .resHit      (resHit),
    .resTarget   (resTarget),
    .resWin      (resWin),
    .resViolation(resViolation)
  );

endmodule

// File: tb/awdDecoderTop_tb.sv
`timescale 1ns/1ps
module awdDecoderTop_tb;

  localparam int NW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, regWrEn, regRdEn, lkValid, lkWrite, lkSecure;
  logic [8:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic [47:0] lkAddr;
  logic        resValid, resHit, resViolation;
  logic [3:0]  resTarget, resWin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] mdl [NW][5];

  awdDecoderTop u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite), .lkSecure(lkSecure),
    .resValid(resValid), .resHit(resHit), .resTarget(resTarget),
    .resWin(resWin), .resViolation(resViolation)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(int w, int f, logic [31:0] d);
    logic [31:0] v;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 9'(w * 32 + f * 4); regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (f < 5) begin
      v = d;
      if (f == 2 || f == 3) v[3:0] = 4'h0;
      if (w == 0 && f == 0) v[0] = 1'b1;
      mdl[w][f] = v;
    end
  endtask

  task automatic regRead(int w, int f, string req);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 9'(w * 32 + f * 4);
    @(negedge clk);
    regRdEn = 1'b0;
    chk(req, $sformatf("read w%0d f%0d", w, f), regRdata, (f < 5) ? mdl[w][f] : 32'h0);
  endtask

  // {valid, hit, violation, win[3:0], target[3:0]}
  function automatic logic [10:0] expLook(logic [47:0] a, bit wr, bit sec);
    logic [27:0] g, lo;
    bit found, m, viol, hit;
    int sel, bi;
    g = a[47:20]; found = 1'b0; sel = 0;
    for (int w = 0; w < NW; w++) begin
      lo = mdl[w][2][31:4];
      if (w == 0) m = mdl[0][0][0] && (g >= lo) && ({1'b0, g} < ({1'b0, lo} + 29'd16));
      else        m = mdl[w][0][0] && (g >= lo) && (g <= mdl[w][3][31:4]);
      if (m && !found) begin found = 1'b1; sel = w; end
    end
    bi   = ((sel != 0) ? 2 : 0) + (wr ? 0 : 1);
    viol = found && !sec && mdl[sel][1][bi];
    hit  = found && !viol;
    return {1'b1, hit, viol, (found ? 4'(sel) : 4'h0), (hit ? mdl[sel][0][11:8] : 4'h0)};
  endfunction

  task automatic lookup(logic [47:0] a, bit wr, bit sec, string req);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a; lkWrite = wr; lkSecure = sec;
    @(negedge clk);
    lkValid = 1'b0;
    chk(req, $sformatf("lookup %0h wr%0d sec%0d", a, wr, sec),
        {21'h0, resValid, resHit, resViolation, resWin, resTarget},
        {21'h0, expLook(a, wr, sec)});
  endtask

  function automatic logic [47:0] granAddr(int g);
    return {28'(g), 20'h5A5A5};
  endfunction

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0; regAddr = '0; regWdata = '0;
    lkValid = 1'b0; lkAddr = '0; lkWrite = 1'b0; lkSecure = 1'b0;
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 5; f++) mdl[w][f] = 32'h0;
    mdl[0][0] = 32'h1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset contents
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 5; f++) regRead(w, f, "R1");

    // R4 window 0 enable sticks
    regWrite(0, 0, 32'h0000_0300);
    regRead(0, 0, "R4");
    // R3 low nibble of bounds
    regWrite(3, 2, 32'hFFFF_FFFF);
    regRead(3, 2, "R3");
    regWrite(3, 3, 32'h1234_567F);
    regRead(3, 3, "R3");
    // R2 unmapped offset and route flags
    regWrite(2, 5, 32'hDEAD_BEEF);
    regRead(2, 5, "R2");
    regRead(2, 7, "R2");
    regWrite(1, 4, 32'h0000_0003);
    regRead(1, 4, "R2");

    // R6 window 0 spans 16 granules; its end register is ignored
    regWrite(0, 2, 32'h0000_0400);
    regWrite(0, 3, 32'h0000_1000);
    lookup(granAddr(32'h40), 1'b0, 1'b0, "R6");
    lookup(granAddr(32'h4F), 1'b1, 1'b0, "R6");
    lookup(granAddr(32'h50), 1'b0, 1'b0, "R6");
    lookup(granAddr(32'h3F), 1'b0, 1'b0, "R9");

    // R5 inclusive bounds, R7 target
    regWrite(5, 2, 32'h0000_0100);
    regWrite(5, 3, 32'h0000_01F0);
    regWrite(5, 0, 32'h0000_0701);
    lookup(granAddr(32'h1F), 1'b0, 1'b1, "R5");
    lookup(granAddr(32'h10), 1'b1, 1'b0, "R7");
    lookup(granAddr(32'h20), 1'b0, 1'b0, "R9");
    lookup(granAddr(32'h0F), 1'b0, 1'b0, "R9");

    // R8 overlap: window 2 beats window 5
    regWrite(2, 2, 32'h0000_0180);
    regWrite(2, 3, 32'h0000_0300);
    regWrite(2, 0, 32'h0000_0301);
    lookup(granAddr(32'h1A), 1'b0, 1'b0, "R8");

    // R10 security on a data window and on window 0
    regWrite(2, 1, 32'h0000_0008);
    lookup(granAddr(32'h1A), 1'b0, 1'b0, "R10");
    lookup(granAddr(32'h1A), 1'b0, 1'b1, "R10");
    lookup(granAddr(32'h1A), 1'b1, 1'b0, "R10");
    regWrite(0, 1, 32'h0000_0001);
    lookup(granAddr(32'h42), 1'b1, 1'b0, "R10");
    lookup(granAddr(32'h42), 1'b0, 1'b0, "R10");

    // R5 disabled window falls through to the next match
    regWrite(2, 0, 32'h0000_0300);
    lookup(granAddr(32'h1A), 1'b0, 1'b0, "R5");

    // R11 no lookup, no valid
    @(negedge clk);
    chk("R11", "idle valid", {31'h0, resValid}, 32'h0);

    // constrained random phase
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 600; i++) begin
      int r, w, f;
      logic [31:0] d;
      r = $urandom_range(0, 9);
      if (r < 3) begin
        w = $urandom_range(0, NW - 1);
        f = $urandom_range(0, 5);
        d = $urandom;
        if (f == 2 || f == 3) d = {21'h0, 7'($urandom_range(0, 127)), d[3:0]};
        else if (f == 1)      d = {28'h0, d[3:0]};
        regWrite(w, f, d);
      end else if (r == 3) begin
        regRead($urandom_range(0, NW - 1), $urandom_range(0, 7), "R2");
      end else begin
        lookup({28'($urandom_range(0, 143)), 20'($urandom)},
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8");
      end
    end

    finishRun();
  end

endmodule